// File: doc/BRIEF.md
# Codec FIFO Status and Interrupt Unit

This unit keeps track of four 8-entry FIFOs that sit in front of a multimedia codec port: an audio pair and a telecom pair, each with a transmit and a receive FIFO. It keeps one occupancy counter for each FIFO and updates it from push and pop strobes. From these counts it forms service requests, not-full and not-empty flags, and sticky error bits. All of these are gathered into one 32-bit status word. The FIFO storage and the serial codec link are outside the block.

The transmit FIFOs ask for service when they are low, at four or fewer entries. The receive FIFOs ask for service when they are high, at six or more entries. While the port is disabled, every service request reads low. A pop on an empty transmit FIFO latches an underrun. A push on a full receive FIFO latches an overrun. Either error stays set until software writes a 1 to its bit. Each service or error bit raises an interrupt request only when its mask bit is set. Software should clear any latched errors before it enables the port.

Top module: `codec_fifo_status`

## Requirements
- R1: Status bit 0 (audio transmit service) is 1 exactly when `en_i` is high and the audio transmit FIFO (index 0) holds 4 or fewer entries.
- R2: Status bit 1 (audio receive service) is 1 exactly when `en_i` is high and the audio receive FIFO (index 1) holds 6 or more entries.
- R3: Status bits 2 and 3 follow the same thresholds for the telecom transmit FIFO (index 2) and the telecom receive FIFO (index 3).
- R4: While `en_i` is low, status bits 3:0 are all 0, whatever the counts are.
- R5: A pop on an empty transmit FIFO sets its underrun bit (bit 4 for audio, bit 6 for telecom) and leaves its count at 0.
- R6: A push on a full receive FIFO (8 entries) sets its overrun bit (bit 5 for audio, bit 7 for telecom) and leaves its count at 8.
- R7: An error bit stays set until a register write carries a 1 in that bit position. Writing 0 there has no effect. Errors latch whether the port is enabled or not. If a new error and its clear arrive in the same cycle, the bit stays set.
- R8: Bit 8 is audio transmit not-full, bit 9 is audio receive not-empty, bit 10 is telecom transmit not-full and bit 11 is telecom receive not-empty. After reset the status word reads 0x00000500.
- R9: Bits 31:12 always read 0. A write has no effect on any bit outside 7:4.
- R10: `irq_src_o[k]` equals status bit k AND `mask_i[k]` for k = 0 to 7, and `irq_o` is the OR of `irq_src_o`.
- R11: A push and a pop on the same FIFO in the same cycle are each accepted when legal, and the count moves by the net amount. A rejected strobe changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Port enable; gates the service requests |
| push_i | input | 4 | Push strobe for each FIFO (0 audio tx, 1 audio rx, 2 telecom tx, 3 telecom rx) |
| pop_i | input | 4 | Pop strobe for each FIFO, same indexing |
| mask_i | input | 8 | Interrupt mask for status bits 7:0 |
| reg_we_i | input | 1 | Status register write strobe |
| reg_wdata_i | input | 32 | Write data; a 1 in bits 7:4 clears that error |
| reg_rdata_o | output | 32 | Status word |
| irq_src_o | output | 8 | Masked interrupt request for each source |
| irq_o | output | 1 | OR of all masked requests |
| level_o | output | 16 | Occupancy counts, 4 bits per FIFO, FIFO 0 in the low bits |

## Verification
The bench builds the block with its default parameters: depth 8, a transmit threshold of 4 and a receive threshold of 6. With these values a handful of pushes reaches every threshold edge (4/5 and 5/6), the full and empty limits, and both rejected-strobe cases. A reference model of the counts and sticky errors, built from the requirements, predicts the whole status word, the levels and the interrupts after every step. The checks also cover errors latched while the port is disabled and a clear that lands in the same cycle as a new error.

// File: rtl/codec_stat_pkg.sv
package codec_stat_pkg;
  localparam int unsigned NUM_FIFO = 4;
  localparam int unsigned SVC_LSB  = 0;
  localparam int unsigned ERR_LSB  = 4;
  localparam int unsigned FLG_LSB  = 8;
  localparam int unsigned USED_W   = 12;

  typedef enum logic [1:0] {
    FIFO_AUD_TX = 2'd0,
    FIFO_AUD_RX = 2'd1,
    FIFO_TEL_TX = 2'd2,
    FIFO_TEL_RX = 2'd3
  } fifo_id_e;
endpackage

// File: rtl/codec_fifo_track.sv
module codec_fifo_track #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned CNT_W  = 4,
  parameter bit          IS_TX  = 1'b1,
  parameter int unsigned TX_LVL = 4,
  parameter int unsigned RX_LVL = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             svc_o,
  output logic             err_o,
  output logic             nf_o,
  output logic             ne_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [CNT_W-1:0] cnt_q;
  logic             err_q;
  logic             full, empty, push_ok, pop_ok, err_evt;

  assign full    = (cnt_q == FULL_CNT);
  assign empty   = (cnt_q == '0);
  assign push_ok = push_i && !full;
  assign pop_ok  = pop_i && !empty;

  generate
    if (IS_TX) begin : g_tx
      assign err_evt = pop_i && empty;
      assign svc_o   = en_i && (cnt_q <= CNT_W'(TX_LVL));
    end else begin : g_rx
      assign err_evt = push_i && full;
      assign svc_o   = en_i && (cnt_q >= CNT_W'(RX_LVL));
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (push_ok && !pop_ok) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (pop_ok && !push_ok) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // new event wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      err_q <= 1'b0;
    else if (err_evt) err_q <= 1'b1;
    else if (clr_i)   err_q <= 1'b0;
  end

  assign cnt_o = cnt_q;
  assign err_o = err_q;
  assign nf_o  = !full;
  assign ne_o  = !empty;
endmodule

// File: rtl/codec_irq_gate.sv
module codec_irq_gate #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] src_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] req_o,
  output logic         any_o
);
  assign req_o = src_i & mask_i;
  assign any_o = |req_o;
endmodule

// File: rtl/codec_fifo_status.sv
module codec_fifo_status
  import codec_stat_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned TX_LVL = 4,
  parameter int unsigned RX_LVL = 6,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      en_i,
  input  logic [NUM_FIFO-1:0]       push_i,
  input  logic [NUM_FIFO-1:0]       pop_i,
  input  logic [7:0]                mask_i,
  input  logic                      reg_we_i,
  input  logic [31:0]               reg_wdata_i,
  output logic [31:0]               reg_rdata_o,
  output logic [7:0]                irq_src_o,
  output logic                      irq_o,
  output logic [NUM_FIFO*CNT_W-1:0] level_o
);
  logic [NUM_FIFO-1:0] svc, err, nf, ne, clr;
  logic [USED_W-1:0]   stat;

  for (genvar i = 0; i < NUM_FIFO; i++) begin : g_fifo
    localparam bit TX = (i % 2 == 0);
    assign clr[i] = reg_we_i && reg_wdata_i[ERR_LSB+i];

    codec_fifo_track #(
      .DEPTH (DEPTH),
      .CNT_W (CNT_W),
      .IS_TX (TX),
      .TX_LVL(TX_LVL),
      .RX_LVL(RX_LVL)
    ) u_trk (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (en_i),
      .push_i(push_i[i]),
      .pop_i (pop_i[i]),
      .clr_i (clr[i]),
      .cnt_o (level_o[i*CNT_W +: CNT_W]),
      .svc_o (svc[i]),
      .err_o (err[i]),
      .nf_o  (nf[i]),
      .ne_o  (ne[i])
    );

    assign stat[SVC_LSB+i] = svc[i];
    assign stat[ERR_LSB+i] = err[i];
    // transmit side reports not-full, receive side not-empty
    assign stat[FLG_LSB+i] = TX ? nf[i] : ne[i];
  end

  assign reg_rdata_o = {{(32-USED_W){1'b0}}, stat};

  logic unused_wdata;
  assign unused_wdata = ^{reg_wdata_i[31:ERR_LSB+NUM_FIFO], reg_wdata_i[ERR_LSB-1:0]};

  codec_irq_gate #(.N(8)) u_irq (
    .src_i (stat[7:0]),
    .mask_i(mask_i),
    .req_o (irq_src_o),
    .any_o (irq_o)
  );
endmodule

// File: rtl/codec_fifo_status_chk.sv
module codec_fifo_status_chk #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned TX_LVL = 4,
  parameter int unsigned RX_LVL = 6,
  parameter int unsigned CNT_W  = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               en_i,
  input logic [3:0]         push_i,
  input logic [3:0]         pop_i,
  input logic [7:0]         mask_i,
  input logic               reg_we_i,
  input logic [31:0]        reg_wdata_i,
  input logic [31:0]        reg_rdata_o,
  input logic [7:0]         irq_src_o,
  input logic               irq_o,
  input logic [4*CNT_W-1:0] level_o
);
  logic [CNT_W-1:0] lv0, lv1;
  assign lv0 = level_o[0 +: CNT_W];
  assign lv1 = level_o[CNT_W +: CNT_W];

  p_tx_svc_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && lv0 <= CNT_W'(TX_LVL)) |-> reg_rdata_o[0]);
  p_rx_svc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lv1 < CNT_W'(RX_LVL)) |-> !reg_rdata_o[1]);
  p_svc_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (reg_rdata_o[3:0] == 4'b0));
  p_underrun_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lv0 == '0 && pop_i[0] && !push_i[0]) |=> (lv0 == '0 && reg_rdata_o[4]));
  p_overrun_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lv1 == CNT_W'(DEPTH) && push_i[1] && !pop_i[1]) |=> (lv1 == CNT_W'(DEPTH) && reg_rdata_o[5]));
  p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[4] && !(reg_we_i && reg_wdata_i[4])) |=> reg_rdata_o[4]);
  p_rsvd_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[31:12] == 20'b0);
  p_irq_or_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == |(reg_rdata_o[7:0] & mask_i));
endmodule

bind codec_fifo_status codec_fifo_status_chk #(
  .DEPTH(DEPTH), .TX_LVL(TX_LVL), .RX_LVL(RX_LVL), .CNT_W(CNT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .push_i(push_i), .pop_i(pop_i),
  .mask_i(mask_i), .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o), .irq_src_o(irq_src_o), .irq_o(irq_o), .level_o(level_o)
);

// File: tb/codec_fifo_status_bench.sv
module codec_fifo_status_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [3:0]  push_i = '0, pop_i = '0;
  logic [7:0]  mask_i = '0;
  logic        reg_we_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [7:0]  irq_src_o;
  logic        irq_o;
  logic [15:0] level_o;

  int total = 0, bad = 0;
  bit done = 0;
  int m_cnt [4];
  bit m_err [4];

  always #10 clk_i = ~clk_i;

  codec_fifo_status u_codec_fifo_status (.*);

  function automatic logic [31:0] exp_stat();
    logic [31:0] s = '0;
    for (int i = 0; i < 4; i++) begin
      bit tx = (i % 2 == 0);
      s[i]   = en_i && (tx ? (m_cnt[i] <= 4) : (m_cnt[i] >= 6));
      s[4+i] = m_err[i];
      s[8+i] = tx ? (m_cnt[i] != 8) : (m_cnt[i] != 0);
    end
    return s;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    logic [31:0] s = exp_stat();
    logic [15:0] lv;
    for (int i = 0; i < 4; i++) lv[i*4 +: 4] = 4'(m_cnt[i]);
    chk({tag, " status"}, reg_rdata_o, s);
    chk({tag, " level R11"}, {16'b0, level_o}, {16'b0, lv});
    chk({tag, " irq R10"}, {23'b0, irq_o, irq_src_o}, {23'b0, |(s[7:0] & mask_i), s[7:0] & mask_i});
  endtask

  // one clock with strobes, model update, then check
  task automatic step(logic [3:0] pu, logic [3:0] po, logic we, logic [31:0] wd, string tag);
    @(negedge clk_i);
    push_i = pu; pop_i = po; reg_we_i = we; reg_wdata_i = wd;
    @(negedge clk_i);
    push_i = '0; pop_i = '0; reg_we_i = 1'b0; reg_wdata_i = '0;
    for (int i = 0; i < 4; i++) begin
      bit tx = (i % 2 == 0);
      bit full = (m_cnt[i] == 8), empty = (m_cnt[i] == 0);
      bit pok = pu[i] && !full, ook = po[i] && !empty;
      bit ev = tx ? (po[i] && empty) : (pu[i] && full);
      m_err[i] = ev || (m_err[i] && !(we && wd[4+i]));
      m_cnt[i] = m_cnt[i] + int'(pok) - int'(ook);
    end
    chk_all(tag);
  endtask

  task automatic t_reset();
    chk("R8 reset word", reg_rdata_o, 32'h0000_0500);
    chk_all("R8 reset");
  endtask

  task automatic t_tx_thresh();
    en_i = 1'b1; mask_i = 8'hff;
    for (int k = 0; k < 4; k++) step(4'b0001, 4'b0, 0, '0, "R1 fill");
    chk("R1 at 4", {31'b0, reg_rdata_o[0]}, 32'd1);
    step(4'b0001, 4'b0, 0, '0, "R1 at 5");
    chk("R1 bit0 at 5", {31'b0, reg_rdata_o[0]}, 32'd0);
    for (int k = 0; k < 3; k++) step(4'b0001, 4'b0, 0, '0, "R8 fill");
    chk("R8 audio tx full", {31'b0, reg_rdata_o[8]}, 32'd0);
  endtask

  task automatic t_rx_thresh();
    for (int k = 0; k < 5; k++) step(4'b0010, 4'b0, 0, '0, "R2 fill");
    chk("R2 at 5", {31'b0, reg_rdata_o[1]}, 32'd0);
    step(4'b0010, 4'b0, 0, '0, "R2 at 6");
    chk("R2 bit1 at 6", {31'b0, reg_rdata_o[1]}, 32'd1);
  endtask

  task automatic t_telecom();
    for (int k = 0; k < 6; k++) step(4'b1100, 4'b0, 0, '0, "R3 fill");
    chk("R3 tel svc at 6", {30'b0, reg_rdata_o[3:2]}, 32'b10);
    step(4'b0, 4'b0100, 0, '0, "R3 tel tx 5");
    step(4'b0, 4'b0100, 0, '0, "R3 tel tx 4");
    chk("R3 tel tx svc at 4", {31'b0, reg_rdata_o[2]}, 32'd1);
  endtask

  task automatic t_disable();
    @(negedge clk_i); en_i = 1'b0;
    #1 chk("R4 svc off", {28'b0, reg_rdata_o[3:0]}, 32'd0);
    chk_all("R4 disabled");
    @(negedge clk_i); en_i = 1'b1;
    #1 chk_all("R4 reenabled");
  endtask

  task automatic t_rx_overrun();
    step(4'b0010, 4'b0, 0, '0, "R6 to 7");
    step(4'b0010, 4'b0, 0, '0, "R6 to 8");
    step(4'b0010, 4'b0, 0, '0, "R6 push full");
    chk("R6 aro set", {31'b0, reg_rdata_o[5]}, 32'd1);
    for (int k = 0; k < 2; k++) step(4'b1000, 4'b0, 0, '0, "R6 tel fill");
    step(4'b1000, 4'b0, 0, '0, "R6 tel push full");
    chk("R6 tro set", {31'b0, reg_rdata_o[7]}, 32'd1);
  endtask

  task automatic t_sticky();
    step(4'b0, 4'b0, 1, 32'hffff_ff0f, "R7 write zeros to errs");
    chk("R7 write 0 no effect", {28'b0, reg_rdata_o[7:4]}, 32'b1010);
    step(4'b0, 4'b0, 1, 32'h0000_0020, "R7 clear aro");
    chk("R7 aro cleared", {31'b0, reg_rdata_o[5]}, 32'd0);
    step(4'b0, 4'b0, 1, 32'h0000_0080, "R7 clear tro");
  endtask

  task automatic t_underrun();
    for (int k = 0; k < 8; k++) step(4'b0, 4'b0001, 0, '0, "R5 drain");
    for (int k = 0; k < 4; k++) step(4'b0, 4'b0100, 0, '0, "R5 tel drain");
    @(negedge clk_i); en_i = 1'b0;
    step(4'b0, 4'b0101, 0, '0, "R5 pop empty while disabled");
    chk("R5 atu ttu set", {28'b0, reg_rdata_o[7:4]}, 32'b0101);
    step(4'b0, 4'b0, 0, '0, "R7 persist");
    @(negedge clk_i); en_i = 1'b1;
    #1 chk("R7 persists after enable", {28'b0, reg_rdata_o[7:4]}, 32'b0101);
    step(4'b0, 4'b0001, 1, 32'h10, "R7 set beats clear");
    chk("R7 set wins", {31'b0, reg_rdata_o[4]}, 32'd1);
    step(4'b0, 4'b0, 1, 32'h50, "R7 clear both");
  endtask

  task automatic t_reserved_mask();
    step(4'b0, 4'b0, 1, 32'hffff_ff0f, "R9 write ro bits");
    chk("R9 rsvd zero", {12'b0, reg_rdata_o[31:12]}, 32'd0);
    @(negedge clk_i); mask_i = 8'h00;
    #1 chk_all("R10 all masked");
    chk("R10 irq low", {31'b0, irq_o}, 32'd0);
    @(negedge clk_i); mask_i = 8'h01;
    #1 chk_all("R10 mask bit0");
    @(negedge clk_i); mask_i = 8'hff;
  endtask

  task automatic t_simul();
    step(4'b0001, 4'b0001, 0, '0, "R11 push+pop empty");
    chk("R11 level 1", {28'b0, level_o[3:0]}, 32'd1);
    step(4'b0001, 4'b0001, 0, '0, "R11 push+pop net zero");
    step(4'b0, 4'b0, 1, 32'h10, "R11 clear");
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin m_cnt[i] = 0; m_err[i] = 0; end
    #5 t_reset();
    @(negedge clk_i); rst_ni = 1'b1;
    t_tx_thresh();
    t_rx_thresh();
    t_telecom();
    t_disable();
    t_rx_overrun();
    t_sticky();
    t_underrun();
    t_reserved_mask();
    t_simul();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule